// File: doc/BRIEF.md
# Ling Pseudo-Carry Lookahead Adder

A purely combinational binary adder that adds two operands of parameterized width and a carry-in, giving a sum and a carry-out. Instead of carrying true carries through its lookahead, it carries Ling pseudo-carries `h`. Each bit forms a generate `g = a & b` and an OR-based transmit `t = a | b`. The operands are split into 4-bit groups. Every group computes the four pseudo-carries above its base in one flat two-level expression, using the pseudo-carry at its base as input.

A pseudo-carry is one product term shorter than the matching true carry. It stays correct with `t` in place of the XOR propagate because `g & t = g`. The true carry into a bit is recovered just before the sum as `c_i = t_{i-1} & h_i`, and the sum bit is `a_i ^ b_i ^ c_i`. Groups are chained directly: the top pseudo-carry of one group is the base input of the next. The carry-in is the pseudo-carry into bit 0, with the transmit below bit 0 tied to 1. The width must be a multiple of 4.

Top module: `ling_adder`

## Requirements
- R1: `sum_o` equals the low `WIDTH` bits of `a_i + b_i + carry_i` for every operand pair and carry-in value; this is checked exhaustively at `WIDTH = 8`.
- R2: `carry_o` equals bit `WIDTH` of `a_i + b_i + carry_i` (1 when the unsigned result does not fit in `WIDTH` bits); this is checked exhaustively at `WIDTH = 8`.
- R3: When every bit position has exactly one operand bit set (`a_i ^ b_i` all ones), the carry-in travels through every group: `sum_o` is all ones and `carry_o` is 0 for `carry_i = 0`, and `sum_o` is 0 and `carry_o` is 1 for `carry_i = 1`.
- R4: A generate at any group's top bit (bit 4k+3), with both operands set there and all higher bits transmitting, sets `carry_o`; when both operands have bit `WIDTH-1` set, `carry_o` is 1 whatever the lower bits are.
- R5: A bit where both operands are 0 stops any carry: when bit `WIDTH-1` of both operands is 0, `carry_o` is 0; when the kill sits at a group boundary, the result still matches R1 and R2.
- R6: With both operands zero, `sum_o` equals `carry_i` in bit 0 and zeros above it, and `carry_o` is 0 (carry-in enters as the pseudo-carry into bit 0).
- R7: At `WIDTH = 32`, sum and carry-out match `a_i + b_i + carry_i` for pseudo-random operands and for alternating-bit and single-bit operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | first operand |
| b_i | input | WIDTH | second operand |
| carry_i | input | 1 | carry-in, weight 1 |
| sum_o | output | WIDTH | low WIDTH bits of the sum |
| carry_o | output | 1 | carry-out, weight 2^WIDTH |

## Verification
The hardest case to reach is a pseudo-carry term that only matters when a long run of transmitting bits carries a base pseudo-carry across several group boundaries. At 32 bits, random operands almost never produce this. The stimulus therefore builds such cases directly. It sets the XOR of the operands to all ones so that the carry-in crosses every group. It places a single generate at each group's top bit with transmits above it. It places a kill at each group boundary with generates below it. Exhaustive enumeration at 8 bits covers every combination within two chained groups.

// File: rtl/ling_pkg.sv
package ling_pkg;
  localparam int unsigned GRP_W = 4;

  function automatic int unsigned n_groups(input int unsigned width);
    return width / GRP_W;
  endfunction
endpackage

// File: rtl/ling_bit_cell.sv
module ling_bit_cell (
  input  logic a_i,
  input  logic b_i,
  output logic gen_o,
  output logic xmit_o,
  output logic half_o
);
  assign gen_o  = a_i & b_i;
  assign xmit_o = a_i | b_i;
  assign half_o = a_i ^ b_i;
endmodule

// File: rtl/ling_group.sv
// One 4-bit lookahead group. Bit j of the inputs is bit k+j of the word.
// h_o[j] is the pseudo-carry into bit k+j+1; carry_o[j] is the true carry into bit k+j.
module ling_group
  import ling_pkg::*;
(
  input  logic [GRP_W-1:0] gen_i,
  input  logic [GRP_W-2:0] xmit_i,
  input  logic             xmit_prev_i, // t_{k-1}
  input  logic             h_in_i,      // h_k
  output logic [GRP_W-1:0] h_o,
  output logic [GRP_W-1:0] carry_o
);
  logic base;
  assign base = xmit_prev_i & h_in_i;

  // g_j & t_j == g_j lets each term drop its leading transmit factor
  assign h_o[0] = gen_i[0] | base;
  assign h_o[1] = gen_i[1] | gen_i[0] | (xmit_i[0] & base);
  assign h_o[2] = gen_i[2] | gen_i[1] | (xmit_i[1] & gen_i[0])
                | (xmit_i[1] & xmit_i[0] & base);
  assign h_o[3] = gen_i[3] | gen_i[2] | (xmit_i[2] & gen_i[1])
                | (xmit_i[2] & xmit_i[1] & gen_i[0])
                | (xmit_i[2] & xmit_i[1] & xmit_i[0] & base);

  assign carry_o[0] = base;
  for (genvar j = 1; j < GRP_W; j++) begin : g_carry
    assign carry_o[j] = xmit_i[j-1] & h_o[j-1];
  end
endmodule

// File: rtl/ling_sum.sv
module ling_sum #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] half_i,
  input  logic [WIDTH-1:0] carry_i,
  output logic [WIDTH-1:0] sum_o
);
  assign sum_o = half_i ^ carry_i;
endmodule

// File: rtl/ling_adder.sv
module ling_adder
  import ling_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);
  localparam int unsigned NGRP = n_groups(WIDTH);

  logic [WIDTH-1:0] gen, xmit, half, carry;
  logic [NGRP:0]    h_chain;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    ling_bit_cell u_cell (
      .a_i   (a_i[i]),
      .b_i   (b_i[i]),
      .gen_o (gen[i]),
      .xmit_o(xmit[i]),
      .half_o(half[i])
    );
  end

  assign h_chain[0] = carry_i;

  for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
    localparam int unsigned K = gi * GRP_W;
    logic             xmit_prev;
    logic [GRP_W-1:0] h_loc;

    if (gi == 0) begin : g_first
      assign xmit_prev = 1'b1;  // carry-in is h_0 with t_{-1} = 1
    end else begin : g_next
      assign xmit_prev = xmit[K-1];
    end

    ling_group u_group (
      .gen_i      (gen[K +: GRP_W]),
      .xmit_i     (xmit[K +: GRP_W-1]),
      .xmit_prev_i(xmit_prev),
      .h_in_i     (h_chain[gi]),
      .h_o        (h_loc),
      .carry_o    (carry[K +: GRP_W])
    );
    assign h_chain[gi+1] = h_loc[GRP_W-1];
  end

  ling_sum #(.WIDTH(WIDTH)) u_sum (
    .half_i (half),
    .carry_i(carry),
    .sum_o  (sum_o)
  );

  assign carry_o = xmit[WIDTH-1] & h_chain[NGRP];
endmodule

// File: rtl/ling_adder_chk.sv
module ling_adder_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             carry_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             carry_o
);
  logic [WIDTH:0] ref_full;
  assign ref_full = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i};

  always_comb begin
    assert_sum_R1: assert (sum_o == ref_full[WIDTH-1:0])
      else $error("sum mismatch");
    assert_cout_R2: assert (carry_o == ref_full[WIDTH])
      else $error("carry-out mismatch");
    if ((a_i ^ b_i) == {WIDTH{1'b1}}) begin
      assert_transmit_R3: assert (carry_o == carry_i && sum_o == {WIDTH{~carry_i}})
        else $error("full transmit chain wrong");
    end
    if (a_i[WIDTH-1] & b_i[WIDTH-1]) begin
      assert_top_gen_R4: assert (carry_o)
        else $error("top generate lost");
    end
    if (!(a_i[WIDTH-1] | b_i[WIDTH-1])) begin
      assert_top_kill_R5: assert (!carry_o)
        else $error("carry passed a kill");
    end
    if (a_i == '0 && b_i == '0) begin
      assert_cin_only_R6: assert (sum_o == {{(WIDTH-1){1'b0}}, carry_i} && !carry_o)
        else $error("carry-in entry wrong");
    end
  end
endmodule

bind ling_adder ling_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .carry_i(carry_i),
  .sum_o  (sum_o),
  .carry_o(carry_o)
);

// File: tb/ling_adder_bench.sv
`timescale 1ns/1ps
module ling_adder_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  int n_vec  = 0;
  int n_fail = 0;

  logic [7:0]  a8 = '0, b8 = '0, s8;
  logic        c8 = 1'b0, co8;
  logic [31:0] a32 = '0, b32 = '0, s32;
  logic        c32 = 1'b0, co32;

  ling_adder #(.WIDTH(8)) u_ling_adder (
    .a_i(a8), .b_i(b8), .carry_i(c8), .sum_o(s8), .carry_o(co8)
  );
  ling_adder #(.WIDTH(32)) u_ling_adder_w32 (
    .a_i(a32), .b_i(b32), .carry_i(c32), .sum_o(s32), .carry_o(co32)
  );

  task automatic apply8(input logic [7:0] a, input logic [7:0] b, input logic c,
                        input string tag);
    logic [8:0] exp;
    @(posedge clk);
    a8 = a; b8 = b; c8 = c;
    exp = {1'b0, a} + {1'b0, b} + {8'd0, c};
    @(negedge clk);
    n_vec++;
    if ({co8, s8} !== exp) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h cin=%0d got %h expected %h",
               tag, a, b, c, {co8, s8}, exp);
    end
  endtask

  task automatic apply32(input logic [31:0] a, input logic [31:0] b, input logic c,
                         input string tag);
    logic [32:0] exp;
    @(posedge clk);
    a32 = a; b32 = b; c32 = c;
    exp = {1'b0, a} + {1'b0, b} + {32'd0, c};
    @(negedge clk);
    n_vec++;
    if ({co32, s32} !== exp) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h cin=%0d got %h expected %h",
               tag, a, b, c, {co32, s32}, exp);
    end
  endtask

  // idle state: all-zero inputs give zero outputs
  task automatic t_idle();
    apply8(8'h00, 8'h00, 1'b0, "R6 idle w8");
    apply32(32'h0, 32'h0, 1'b0, "R6 idle w32");
  endtask

  // R1, R2: every operand pair and carry-in at width 8
  task automatic t_exhaustive8();
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++)
          apply8(a[7:0], b[7:0], c[0], "R1/R2 exhaustive w8");
  endtask

  // R6: carry-in alone
  task automatic t_cin_only();
    apply8(8'h00, 8'h00, 1'b1, "R6 cin only w8");
    apply32(32'h0, 32'h0, 1'b1, "R6 cin only w32");
  endtask

  // R3: carry-in through every group
  task automatic t_full_transmit();
    for (int c = 0; c < 2; c++) begin
      apply32(32'hFFFF_FFFF, 32'h0, c[0], "R3 transmit ones/zero");
      apply32(32'hAAAA_AAAA, 32'h5555_5555, c[0], "R3 transmit alternating");
      apply32(32'h0F0F_0F0F, 32'hF0F0_F0F0, c[0], "R3 transmit nibbles");
      apply8(8'hC3, 8'h3C, c[0], "R3 transmit w8");
    end
  endtask

  // R4: generate at each group's top bit with transmits above
  task automatic t_top_generate();
    for (int k = 3; k < 32; k += 4) begin
      logic [31:0] bit_k;
      bit_k = 32'h1 << k;
      apply32(bit_k, ~(bit_k - 32'h1), 1'b0, "R4 group-top generate");
    end
    apply32(32'h8000_0000, 32'h8000_0000, 1'b0, "R4 msb generate");
  endtask

  // R5: kill at each group boundary with generates below
  task automatic t_kill_block();
    for (int k = 4; k < 32; k += 4) begin
      logic [31:0] m;
      m = ~(32'h1 << k);
      apply32(m, m, 1'b1, "R5 kill at boundary");
    end
    apply32(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, "R5 msb kill");
  endtask

  // R7: pseudo-random operands at width 32
  task automatic t_random32();
    logic [31:0] lfsr_a, lfsr_b;
    lfsr_a = 32'h1234_5678;
    lfsr_b = 32'h9ABC_DEF1;
    for (int i = 0; i < 2000; i++) begin
      lfsr_a = {lfsr_a[30:0], lfsr_a[31] ^ lfsr_a[21] ^ lfsr_a[1] ^ lfsr_a[0]};
      lfsr_b = {lfsr_b[30:0], lfsr_b[31] ^ lfsr_b[21] ^ lfsr_b[1] ^ lfsr_b[0]};
      apply32(lfsr_a, lfsr_b, lfsr_a[5] ^ lfsr_b[9], "R7 random w32");
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_idle();
    t_cin_only();
    t_full_transmit();
    t_top_generate();
    t_kill_block();
    t_random32();
    t_exhaustive8();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule